// File: doc/BRIEF.md
# Sequential Restoring Shift-Subtract Divider

This block divides a 2K-bit dividend by a K-bit divisor over several clock cycles. It returns a K-bit quotient and a K-bit remainder. A single 2K-bit partial-remainder register does two jobs. Its upper half carries the running remainder, and its lower half collects the quotient bits that enter from the right as the register moves left.

Each iteration subtracts the divisor from the upper half of the shifted value, every time. A selector then keeps the difference or restores the old value. It decides from the bit that left the top of the register and the borrow of the subtraction. A two's-complement mode is available. It takes the magnitudes of both operands, divides them unsigned, and then corrects the signs.

Before iterating, the block detects two cases: a zero divisor, and a quotient that cannot fit in K bits. Either case finishes at once.

A client asserts `start` for one cycle with the operands and then waits for the one-cycle `done` pulse.

Top module: `rsd_divider`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done`, `overflow`, `div_zero`, `quotient` and `remainder` are all 0.
- R2: With `signed_mode`=0, a nonzero divisor x and dividend z whose upper K bits are below x, the results satisfy z = quotient·x + remainder with remainder < x. For K=4, 0x75/0xA gives 0xB r 0x7 and 0x0D/0x5 gives 0x2 r 0x3.
- R3: If the upper K bits of the dividend magnitude are greater than or equal to the divisor magnitude, the quotient would not fit in K bits. The block then raises `overflow`, leaves `div_zero` at 0, and drives `quotient` and `remainder` to 0. `busy` stays low, and `done` is high in the cycle after the edge that accepted `start`.
- R4: A divisor of 0 raises `div_zero` and leaves `overflow` at 0, even when the R3 condition would hold. `quotient` and `remainder` are 0, and `done` comes with the same one-edge latency as in R3.
- R5: For an operation that iterates, `busy` is high for exactly K cycles. `done` is high in the cycle after the (K+1)-th rising edge, counting the edge that accepted `start` as the first. `busy` and `done` are never high together.
- R6: `done` is high for exactly one cycle. `quotient`, `remainder`, `overflow` and `div_zero` change only on the edge that raises `done`. They hold their values while idle and during the next operation, until that operation completes.
- R7: `start` is ignored while `busy` is high. The running operation completes with its original operands and latency, and no further `done` follows.
- R8: With `signed_mode`=1, the dividend and divisor are two's complement. The quotient is truncated toward zero, and the remainder takes the sign of the dividend: 5/3 = 1 r 2, 5/−3 = −1 r 2, −5/3 = −1 r −2, −5/−3 = 1 r −2.
- R9: With `signed_mode`=1, a result that passes the R3 check can still exceed the signed K-bit range. That happens when the quotient magnitude is above 2^(K−1) and the operand signs differ, or when it is at least 2^(K−1) and the signs match. Such a result raises `overflow` and drives `quotient` and `remainder` to 0.
- R10: During iteration, the remainder half of the partial-remainder register stays strictly below the divisor magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division; accepted only while idle |
| signed_mode | input | 1 | 1: operands and results are two's complement |
| dividend | input | 2K | Dividend |
| divisor | input | K | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | K | Quotient |
| remainder | output | K | Remainder |
| overflow | output | 1 | Quotient does not fit in K bits (or the signed range) |
| div_zero | output | 1 | Divisor was zero |

## Verification
The bench builds the divider with K=4, so the 8-bit dividend and 4-bit divisor span only 4096 combinations per mode. It runs every one of them in both unsigned and signed mode. That sweep reaches every boundary case: the zero divisor, early overflow right at the limit, the most negative dividend and divisor, and quotients at the edge of the signed range on both sides. Latency, holding of results between operations, and a `start` issued during a run are checked on the same small configuration.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

   typedef enum logic [0:0] {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;

endpackage

// File: rtl/rsd_operand_prep.sv
module rsd_operand_prep #(
   parameter int K         = 16,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [2*K-1:0] dividend,
   input  logic [K-1:0]   divisor,
   input  logic           signed_mode,
   output logic [2*K-1:0] mag_z,
   output logic [K-1:0]   mag_x,
   output logic           neg_z,
   output logic           neg_x,
   output logic           zero_div,
   output logic           early_ovf
);

   localparam int ZW = 2 * K;

   initial begin
      assert (K >= 2) else $error("rsd_operand_prep: K must be at least 2");
   end

   generate
      if (SIGNED_EN) begin : g_signed
         always_comb begin
            neg_z = signed_mode & dividend[ZW-1];
            neg_x = signed_mode & divisor[K-1];
            mag_z = neg_z ? (~dividend + ZW'(1)) : dividend;
            mag_x = neg_x ? (~divisor + K'(1)) : divisor;
         end
      end else begin : g_unsigned
         always_comb begin
            neg_z = 1'b0;
            neg_x = 1'b0;
            mag_z = dividend;
            mag_x = divisor;
         end
      end
   endgenerate

   // The quotient fits in K bits only if the upper half of the dividend
   // is below the divisor.
   always_comb begin
      zero_div  = (divisor == '0);
      early_ovf = (mag_z[ZW-1:K] >= mag_x);
   end

endmodule

// File: rtl/rsd_step.sv
module rsd_step #(
   parameter int K = 16
) (
   input  logic [2*K-1:0] pr_cur,
   input  logic [K-1:0]   dv,
   output logic [2*K-1:0] pr_next,
   output logic           qbit
);

   localparam int ZW = 2 * K;

   initial begin
      assert (K >= 2) else $error("rsd_step: K must be at least 2");
   end

   logic          top_out;
   logic [K-1:0]  hi_shift;
   logic [K:0]    trial;
   logic          borrow;

   // The left shift is in the wiring: the bit leaving the top and the
   // shifted upper half feed the subtractor directly.
   always_comb begin
      top_out  = pr_cur[ZW-1];
      hi_shift = pr_cur[ZW-2:K-1];
      trial    = {1'b0, hi_shift} - {1'b0, dv};
      borrow   = trial[K];
      qbit     = top_out | ~borrow;
      pr_next  = {(qbit ? trial[K-1:0] : hi_shift), pr_cur[K-2:0], qbit};
   end

endmodule

// File: rtl/rsd_result_fix.sv
module rsd_result_fix #(
   parameter int K         = 16,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic [K-1:0] raw_q,
   input  logic [K-1:0] raw_r,
   input  logic         smode,
   input  logic         neg_z,
   input  logic         neg_x,
   output logic [K-1:0] fix_q,
   output logic [K-1:0] fix_r,
   output logic         late_ovf
);

   localparam logic [K-1:0] HALF = {1'b1, {(K-1){1'b0}}};

   initial begin
      assert (K >= 2) else $error("rsd_result_fix: K must be at least 2");
   end

   generate
      if (SIGNED_EN) begin : g_signed
         logic neg_q;
         always_comb begin
            neg_q    = neg_z ^ neg_x;
            late_ovf = smode & (neg_q ? (raw_q > HALF) : (raw_q >= HALF));
            fix_q    = neg_q ? (~raw_q + K'(1)) : raw_q;
            fix_r    = neg_z ? (~raw_r + K'(1)) : raw_r;
         end
      end else begin : g_unsigned
         always_comb begin
            late_ovf = 1'b0;
            fix_q    = raw_q;
            fix_r    = raw_r;
         end
      end
   endgenerate

endmodule

// File: rtl/rsd_divider.sv
module rsd_divider
   import rsd_pkg::*;
#(
   parameter int K         = 16,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           signed_mode,
   input  logic [2*K-1:0] dividend,
   input  logic [K-1:0]   divisor,
   output logic           busy,
   output logic           done,
   output logic [K-1:0]   quotient,
   output logic [K-1:0]   remainder,
   output logic           overflow,
   output logic           div_zero
);

   localparam int ZW = 2 * K;
   localparam int CW = $clog2(K + 1);

   initial begin
      assert (K >= 2) else $error("rsd_divider: K must be at least 2");
   end

   phase_t          phase;
   logic [CW-1:0]   cnt;
   logic [ZW-1:0]   pr;
   logic [K-1:0]    dv;
   logic            nz_q, nx_q, smode_q;
   logic            done_q, ovf_q, dz_q;
   logic [K-1:0]    quot_q, rem_q;

   logic [ZW-1:0]   mag_z;
   logic [K-1:0]    mag_x;
   logic            neg_z, neg_x, zero_div, early_ovf;
   logic [ZW-1:0]   pr_next;
   logic            qbit;
   logic [K-1:0]    fix_q, fix_r;
   logic            late_ovf;
   logic [K-1:0]    pr_hi;

   rsd_operand_prep #(.K(K), .SIGNED_EN(SIGNED_EN)) u_prep (
      .dividend    (dividend),
      .divisor     (divisor),
      .signed_mode (signed_mode),
      .mag_z       (mag_z),
      .mag_x       (mag_x),
      .neg_z       (neg_z),
      .neg_x       (neg_x),
      .zero_div    (zero_div),
      .early_ovf   (early_ovf)
   );

   rsd_step #(.K(K)) u_step (
      .pr_cur  (pr),
      .dv      (dv),
      .pr_next (pr_next),
      .qbit    (qbit)
   );

   rsd_result_fix #(.K(K), .SIGNED_EN(SIGNED_EN)) u_fix (
      .raw_q    (pr_next[K-1:0]),
      .raw_r    (pr_next[ZW-1:K]),
      .smode    (smode_q),
      .neg_z    (nz_q),
      .neg_x    (nx_q),
      .fix_q    (fix_q),
      .fix_r    (fix_r),
      .late_ovf (late_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         pr      <= '0;
         dv      <= '0;
         nz_q    <= 1'b0;
         nx_q    <= 1'b0;
         smode_q <= 1'b0;
         done_q  <= 1'b0;
         ovf_q   <= 1'b0;
         dz_q    <= 1'b0;
         quot_q  <= '0;
         rem_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  if (zero_div) begin
                     done_q <= 1'b1;
                     dz_q   <= 1'b1;
                     ovf_q  <= 1'b0;
                     quot_q <= '0;
                     rem_q  <= '0;
                  end else if (early_ovf) begin
                     done_q <= 1'b1;
                     dz_q   <= 1'b0;
                     ovf_q  <= 1'b1;
                     quot_q <= '0;
                     rem_q  <= '0;
                  end else begin
                     phase   <= PH_RUN;
                     cnt     <= CW'(K);
                     pr      <= mag_z;
                     dv      <= mag_x;
                     nz_q    <= neg_z;
                     nx_q    <= neg_x;
                     smode_q <= signed_mode;
                  end
               end
            end
            PH_RUN: begin
               pr  <= pr_next;
               cnt <= cnt - CW'(1);
               if (cnt == CW'(1)) begin
                  phase  <= PH_IDLE;
                  done_q <= 1'b1;
                  dz_q   <= 1'b0;
                  ovf_q  <= late_ovf;
                  quot_q <= late_ovf ? '0 : fix_q;
                  rem_q  <= late_ovf ? '0 : fix_r;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy      = (phase == PH_RUN);
   assign done      = done_q;
   assign quotient  = quot_q;
   assign remainder = rem_q;
   assign overflow  = ovf_q;
   assign div_zero  = dz_q;
   assign pr_hi     = pr[ZW-1:K];

   a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r5_count_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt == CW'(1)) |=> (done && !busy));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (quotient != $past(quotient)) |-> done);

   a_r6_rem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (remainder != $past(remainder)) |-> done);

   a_r4_zero_results: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_zero) |-> (quotient == '0 && remainder == '0 && !overflow));

   a_r3_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(overflow && div_zero));

   a_r7_divisor_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(dv));

   a_r10_pr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pr_hi < dv));

endmodule

// File: tb/tb_rsd_divider.sv
`timescale 1ns/1ps
module tb_rsd_divider;

   localparam int K = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           signed_mode = 1'b0;
   logic [2*K-1:0] dividend = '0;
   logic [K-1:0]   divisor = '0;
   logic           busy, done, overflow, div_zero;
   logic [K-1:0]   quotient, remainder;

   int n_checks = 0;
   int n_fail   = 0;
   int prev_q   = 0;
   int prev_r   = 0;

   always #2 clk = ~clk;

   rsd_divider #(.K(K), .SIGNED_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
      .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
      .quotient(quotient), .remainder(remainder), .overflow(overflow),
      .div_zero(div_zero)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Reference model from the requirements.
   task automatic model(input int z, input int x, input bit s,
                        output int eq, output int er, output bit eo,
                        output bit ed, output string tag);
      int zs, xs, zm, xm, qm, rm;
      bit neg;
      eq = 0; er = 0; eo = 0; ed = 0;
      zs = (s && z >= 128) ? z - 256 : z;
      xs = (s && x >= 8) ? x - 16 : x;
      zm = zs < 0 ? -zs : zs;
      xm = xs < 0 ? -xs : xs;
      if (x == 0) begin
         ed = 1; tag = "R4";
      end else if ((zm >> K) >= xm) begin
         eo = 1; tag = "R3";
      end else begin
         qm  = zm / xm;
         rm  = zm % xm;
         neg = (zs < 0) != (xs < 0);
         if (s && ((neg && qm > 8) || (!neg && qm >= 8))) begin
            eo = 1; tag = "R9";
         end else begin
            eq  = (neg ? -qm : qm) & 15;
            er  = (zs < 0 ? -rm : rm) & 15;
            tag = s ? "R8" : "R2";
         end
      end
   endtask

   task automatic run_op(input int z, input int x, input bit s, input bit poke);
      int eq, er, n;
      bit eo, ed, imm;
      string tag;
      model(z, x, s, eq, er, eo, ed, tag);
      imm = (x == 0) || eo && (tag == "R3");
      @(negedge clk);
      dividend = 8'(z); divisor = 4'(x); signed_mode = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      if (!imm) begin
         check(busy === 1'b1, "R5", "busy after accept", int'(busy), 1);
         check(quotient == 4'(prev_q) && remainder == 4'(prev_r), "R6",
               "results held during run", int'(quotient), prev_q);
      end else begin
         check(busy === 1'b0, "R3", "busy on immediate finish", int'(busy), 0);
      end
      while (!done && n < 40) begin
         if (poke && n == 2) begin
            dividend = 8'h00; divisor = 4'h0; start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         n++;
      end
      check(n == (imm ? 1 : K + 1), imm ? "R3" : "R5", "done latency", n,
            imm ? 1 : K + 1);
      check(int'(quotient) == eq && int'(remainder) == er &&
            overflow == eo && div_zero == ed, tag,
            $sformatf("z=%0d x=%0d s=%0d q/r", z, x, s),
            int'({overflow, div_zero, quotient, remainder}),
            int'({eo, ed, 4'(eq), 4'(er)}));
      prev_q = eq; prev_r = er;
      @(negedge clk);
      check(done === 1'b0, poke ? "R7" : "R6", "done one cycle", int'(done), 0);
   endtask

   initial begin : watchdog
      repeat (180000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && overflow == 0 && div_zero == 0 &&
            quotient == 0 && remainder == 0, "R1", "reset state",
            int'({busy, done, overflow, div_zero, quotient, remainder}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 0 && done == 0 && quotient == 0 && remainder == 0, "R1",
            "after release", int'({busy, done, quotient, remainder}), 0);

      // Known worked examples
      run_op(8'h75, 4'hA, 1'b0, 1'b0);   // R2: 11 r 7
      run_op(8'h0D, 4'h5, 1'b0, 1'b0);   // R2: 2 r 3
      run_op(5, 3, 1'b1, 1'b0);          // R8
      run_op(5, 13, 1'b1, 1'b0);         // R8: 5/-3
      run_op(251, 3, 1'b1, 1'b0);        // R8: -5/3
      run_op(251, 13, 1'b1, 1'b0);       // R8: -5/-3

      // R6: results hold while idle
      repeat (3) @(negedge clk);
      check(quotient == 4'(prev_q) && remainder == 4'(prev_r) && !done, "R6",
            "idle hold", int'(quotient), prev_q);

      // R7: start during a run is ignored
      run_op(8'h75, 4'hA, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R7", "no queued op",
            int'({done, busy}), 0);

      // Exhaustive sweep in both modes (R2, R3, R4, R8, R9)
      for (int s = 0; s < 2; s++)
         for (int z = 0; z < 256; z++)
            for (int x = 0; x < 16; x++)
               run_op(z, x, s[0], 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule